// File: doc/BRIEF.md
# Power Converter Start-Up and Fault Sequencer

This block supervises a DC-DC converter across its life cycle: offset calibration, precharge, controller setup, a ramped start, regulated operation and a latched fault condition. It acts only on cycles where a periodic scheduler tick is high. Every other cycle holds state and outputs unchanged, so the sequencer can run on a fast clock while keeping a slow decision rate.

The sequencer drives the enables for primary-side switching and for the control loops. It also drives a flag that passes synchronous-rectifier control to the continuous/discontinuous conduction monitor, and the voltage reference fed to the outer loop. That reference is ramped toward the requested target by a programmable step in both directions. A new target during regulated operation sends the sequencer back through the ramp state. A fault stays latched until an explicit clear. The clear restarts calibration, and if the fault is still present the sequencer drops straight back into the fault state.

Top module: `pwr_seq_fsm`

## Requirements
- R1: After reset, the state output is 0 (calibration), the voltage reference is 0, and the switching, loop and rectifier-handover outputs are all low.
- R2: State and voltage reference change only on a clock edge where `tick` is high. All other inputs are ignored on cycles without a tick.
- R3: In calibration (state 0), ticks are counted up to CAL_TICKS, and the count restarts every time the state is entered. On the first tick after CAL_TICKS ticks have been counted, with `offs_ready` high, the state moves to precharge (state 1). While `offs_ready` is low the state stays at 0.
- R4: In precharge, a tick with `xfer_go` high is ignored until a tick with `pre_go` high has been seen in this visit. After that, a tick with `xfer_go` high moves to standby (state 2).
- R5: Standby lasts exactly one tick, then moves to soft-start (state 3) with the reference starting from 0.
- R6: `pwm_en` and `loop_en` are high exactly in soft-start and running (state 4). `sr_handover` is high exactly in standby, soft-start and running.
- R7: On each soft-start tick the reference moves toward `vref_target` by `vref_step`, landing exactly on the target when the remaining distance is at most one step. A tick that finds the reference equal to the target moves to running.
- R8: In running, a tick that finds `vref_target` different from the reference returns the state to soft-start, from where the reference ramps up or down. With an unchanged target, running holds.
- R9: A tick with `flt_active` high in any state other than fault (state 5) moves to fault, overriding every other transition, and clears the reference to 0.
- R10: Fault is left only by a tick with `flt_clear` high. That tick moves the state to calibration (state 0) and calibration restarts.
- R11: If `flt_active` is still high when the fault is cleared, the next tick returns the state to fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Scheduler tick; one decision per high cycle |
| offs_ready | input | 1 | Sensor offsets are valid |
| pre_go | input | 1 | Precharge start command |
| xfer_go | input | 1 | Power transfer start command |
| flt_active | input | 1 | A fault condition is present |
| flt_clear | input | 1 | Fault clear command |
| vref_target | input | REF_W | Requested output voltage reference |
| vref_step | input | REF_W | Reference change per soft-start tick |
| state_o | output | 3 | Current state: 0 calibration, 1 precharge, 2 standby, 3 soft-start, 4 running, 5 fault |
| pwm_en | output | 1 | Primary switching enable |
| loop_en | output | 1 | Control loop enable |
| sr_handover | output | 1 | Rectifier control passed to the conduction monitor |
| vref_o | output | REF_W | Ramped voltage reference |

## Verification
The hardest case to reach from the ports is a fault clear while the fault is still present, followed by re-entry on the very next tick. Calibration must also restart correctly after such a clear. The stimulus reaches this case by holding `flt_active` high across the clear tick, then releasing it and clearing again. It then counts the ticks until precharge to show that the calibration count began from zero. The ramp is swept over several targets and steps, including steps larger than the remaining distance in both directions, with a bench model predicting every tick.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_CAL     = 3'd0,
        ST_PRECHG  = 3'd1,
        ST_STANDBY = 3'd2,
        ST_SOFT    = 3'd3,
        ST_RUN     = 3'd4,
        ST_FAULT   = 3'd5
    } seq_state_e;

endpackage

// File: rtl/seq_cal_timer.sv
module seq_cal_timer #(
    parameter int CAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    output logic done
);
    localparam int CW = $clog2(CAL_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CAL_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active)
            cnt_d = '0;
        else if (tick && cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIMIT);

    // R3: count never passes the limit and rises by at most one
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active && cnt_q != LIMIT |=> cnt_q <= $past(cnt_q) + 1'b1);
    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt_q == '0);
endmodule

// File: rtl/seq_ref_ramp.sv
module seq_ref_ramp #(
    parameter int REF_W = 12
) (
    input  logic [REF_W-1:0] cur,
    input  logic [REF_W-1:0] tgt,
    input  logic [REF_W-1:0] step,
    output logic [REF_W-1:0] nxt
);
    logic [REF_W-1:0] gap;

    always_comb begin
        gap = (tgt > cur) ? (tgt - cur) : (cur - tgt);
        if (gap <= step)
            nxt = tgt;
        else if (tgt > cur)
            nxt = cur + step;
        else
            nxt = cur - step;
    end

    // R7: the next value always lies between current and target
    always_comb begin
        if (tgt >= cur) p_ramp_bound_up_r7: assert (nxt >= cur && nxt <= tgt);
        else            p_ramp_bound_dn_r7: assert (nxt <= cur && nxt >= tgt);
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int REF_W     = 12,
    parameter int CAL_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             offs_ready,
    input  logic             pre_go,
    input  logic             xfer_go,
    input  logic             flt_active,
    input  logic             flt_clear,
    input  logic [REF_W-1:0] vref_target,
    input  logic [REF_W-1:0] vref_step,
    output logic [2:0]       state_o,
    output logic             pwm_en,
    output logic             loop_en,
    output logic             sr_handover,
    output logic [REF_W-1:0] vref_o
);
    typedef struct packed {
        seq_state_e       st;
        logic             armed;
        logic [REF_W-1:0] vref;
    } seq_reg_t;

    seq_reg_t         r_d, r_q;
    logic             cal_done;
    logic [REF_W-1:0] ramp_nxt;

    seq_cal_timer #(.CAL_TICKS(CAL_TICKS)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .active (r_q.st == ST_CAL),
        .done   (cal_done)
    );

    seq_ref_ramp #(.REF_W(REF_W)) u_ramp (
        .cur  (r_q.vref),
        .tgt  (vref_target),
        .step (vref_step),
        .nxt  (ramp_nxt)
    );

    always_comb begin
        r_d = r_q;
        if (tick) begin
            if (r_q.st != ST_FAULT && flt_active) begin
                r_d.st    = ST_FAULT;
                r_d.armed = 1'b0;
                r_d.vref  = '0;
            end else begin
                unique case (r_q.st)
                    ST_CAL: begin
                        if (cal_done && offs_ready) r_d.st = ST_PRECHG;
                    end
                    ST_PRECHG: begin
                        if (r_q.armed && xfer_go) begin
                            r_d.st    = ST_STANDBY;
                            r_d.armed = 1'b0;
                        end else if (pre_go) begin
                            r_d.armed = 1'b1;
                        end
                    end
                    ST_STANDBY: begin
                        r_d.st   = ST_SOFT;
                        r_d.vref = '0;
                    end
                    ST_SOFT: begin
                        if (r_q.vref == vref_target) r_d.st = ST_RUN;
                        else                         r_d.vref = ramp_nxt;
                    end
                    ST_RUN: begin
                        if (vref_target != r_q.vref) r_d.st = ST_SOFT;
                    end
                    ST_FAULT: begin
                        if (flt_clear) r_d.st = ST_CAL;
                    end
                    default: r_d.st = ST_FAULT;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_CAL, armed: 1'b0, vref: '0};
        else        r_q <= r_d;
    end

    assign state_o     = r_q.st;
    assign vref_o      = r_q.vref;
    assign pwm_en      = (r_q.st == ST_SOFT) || (r_q.st == ST_RUN);
    assign loop_en     = (r_q.st == ST_SOFT) || (r_q.st == ST_RUN);
    assign sr_handover = (r_q.st == ST_STANDBY) || (r_q.st == ST_SOFT) || (r_q.st == ST_RUN);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_o) && $stable(vref_o));
    p_cal_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_CAL && !cal_done |=> state_o != 3'd1);
    p_run_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 && $past(state_o) != 3'd4 |-> $past(state_o) == 3'd3);
    p_fault_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick && flt_active && r_q.st != ST_FAULT |=> state_o == 3'd5 && vref_o == '0 && !pwm_en);
    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_FAULT && !(tick && flt_clear) |=> state_o == 3'd5);
    p_fault_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_FAULT && tick && flt_clear |=> state_o == 3'd0);
endmodule

// File: tb/pwr_seq_fsm_test.sv
module pwr_seq_fsm_test;
    localparam int W   = 8;
    localparam int CAL = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, offs_ready = 1'b0, pre_go = 1'b0, xfer_go = 1'b0;
    logic         flt_active = 1'b0, flt_clear = 1'b0;
    logic [W-1:0] vref_target = '0, vref_step = 8'd1;
    logic [2:0]   state_o;
    logic         pwm_en, loop_en, sr_handover;
    logic [W-1:0] vref_o;

    int n_chk = 0, n_bad = 0;
    int m_st = 0, m_cnt = 0, m_arm = 0, m_ref = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_seq_fsm #(.REF_W(W), .CAL_TICKS(CAL)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .offs_ready(offs_ready),
        .pre_go(pre_go), .xfer_go(xfer_go), .flt_active(flt_active),
        .flt_clear(flt_clear), .vref_target(vref_target), .vref_step(vref_step),
        .state_o(state_o), .pwm_en(pwm_en), .loop_en(loop_en),
        .sr_handover(sr_handover), .vref_o(vref_o)
    );

    // Model of one tick, from the requirements
    task automatic model_tick();
        int tgt, stp, ns;
        tgt = int'(vref_target);
        stp = int'(vref_step);
        ns  = m_st;
        if (m_st != 5 && flt_active) begin
            ns = 5; m_arm = 0; m_ref = 0;
        end else begin
            case (m_st)
                0: if (m_cnt == CAL && offs_ready) ns = 1;
                1: if (m_arm != 0 && xfer_go) begin ns = 2; m_arm = 0; end
                   else if (pre_go) m_arm = 1;
                2: begin ns = 3; m_ref = 0; end
                3: if (m_ref == tgt) ns = 4;
                   else if (m_ref < tgt) m_ref = (tgt - m_ref <= stp) ? tgt : m_ref + stp;
                   else                  m_ref = (m_ref - tgt <= stp) ? tgt : m_ref - stp;
                4: if (tgt != m_ref) ns = 3;
                5: if (flt_clear) ns = 0;
                default: ;
            endcase
        end
        if (m_st == 0 && m_cnt != CAL) m_cnt++;
        if (ns != 0) m_cnt = 0;
        if (m_st != 0 && ns == 0) m_cnt = 0;
        m_st = ns;
    endtask

    task automatic check(input string tag);
        logic [3+3+W-1:0] act, exp;
        logic             en, sr;
        en  = (m_st == 3 || m_st == 4);
        sr  = (m_st == 2 || m_st == 3 || m_st == 4);
        act = {state_o, pwm_en, loop_en, sr_handover, vref_o};
        exp = {3'(m_st), en, en, sr, W'(m_ref)};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got st=%0d pwm=%0b loop=%0b sr=%0b ref=%0d, expected st=%0d pwm=%0b loop=%0b sr=%0b ref=%0d",
                     tag, state_o, pwm_en, loop_en, sr_handover, vref_o,
                     m_st, en, en, sr, m_ref);
        end
    endtask

    task automatic do_tick(input string tag);
        tick = 1'b1;
        @(posedge clk);
        model_tick();
        @(negedge clk);
        tick = 1'b0;
        check(tag);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic ramp_to(input int tgt, input int stp);
        vref_target = W'(tgt);
        vref_step   = W'(stp);
        for (int i = 0; i < 300 && !(m_st == 4 && m_ref == tgt); i++)
            do_tick((m_st == 4) ? "R8" : "R7");
        do_tick("R8");      // unchanged target holds running
        idle("R2");
    endtask

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: commands without tick are ignored
        pre_go = 1; flt_active = 1; flt_clear = 1; offs_ready = 1;
        idle("R2"); idle("R2"); idle("R2");
        pre_go = 0; flt_active = 0; flt_clear = 0; offs_ready = 0;

        // R3: calibration waits while offsets not ready
        for (int i = 0; i < 6; i++) do_tick("R3");
        offs_ready = 1;
        do_tick("R3");

        // R4: transfer command before precharge command ignored
        xfer_go = 1;
        for (int i = 0; i < 3; i++) do_tick("R4");
        xfer_go = 0; pre_go = 1; do_tick("R4");
        pre_go = 0;  do_tick("R4");
        xfer_go = 1; do_tick("R4");
        xfer_go = 0;
        do_tick("R5");
        check("R6");

        // R7/R8: ramp sweep in both directions
        ramp_to(200, 7);
        check("R6");
        ramp_to(37, 5);
        ramp_to(250, 60);
        ramp_to(0, 255);
        ramp_to(128, 1);
        ramp_to(127, 200);

        // R9: fault during running
        flt_active = 1; do_tick("R9");
        for (int i = 0; i < 3; i++) do_tick("R10");
        // R11: clear while fault persists
        flt_clear = 1; do_tick("R10");
        flt_clear = 0; do_tick("R11");
        flt_active = 0; do_tick("R10");
        flt_clear = 1; do_tick("R10");
        flt_clear = 0;
        for (int i = 0; i < CAL + 1; i++) do_tick("R3");

        // R9: fault in armed precharge; arm must be lost
        pre_go = 1; do_tick("R4");
        pre_go = 0; flt_active = 1; do_tick("R9");
        flt_active = 0; flt_clear = 1; do_tick("R10");
        flt_clear = 0;
        for (int i = 0; i < CAL + 1; i++) do_tick("R3");
        xfer_go = 1; do_tick("R4");
        xfer_go = 0; pre_go = 1; do_tick("R4");
        pre_go = 0; xfer_go = 1; do_tick("R4");
        xfer_go = 0;
        // R9: fault in standby, then in soft-start mid-ramp
        flt_active = 1; do_tick("R9");
        flt_active = 0; flt_clear = 1; do_tick("R10");
        flt_clear = 0;
        for (int i = 0; i < CAL + 1; i++) do_tick("R3");
        pre_go = 1; do_tick("R4");
        pre_go = 0; xfer_go = 1; do_tick("R4");
        xfer_go = 0; vref_target = 8'd100; vref_step = 8'd9;
        do_tick("R5");
        do_tick("R7"); do_tick("R7");
        flt_active = 1; do_tick("R9");
        flt_active = 0;
        idle("R2");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule